// File: doc/BRIEF.md
# Receive Descriptor Sequencer

This block steps a frame-receiving DMA engine through a table of four-word receive descriptors. When a frame arrives, the block takes its byte count, its low timestamp word and a flag that says whether the timestamp applies. It then fetches descriptors one at a time, starting from its current pointer. For each descriptor it decides which of the two buffers receive data and how many bytes go into each. It issues one write request per buffer used and selects the address of the next descriptor.

A frame that is longer than one descriptor's buffers continues in the following descriptors. Every descriptor that received data produces a one-cycle writeback record. The record on the final descriptor carries the frame's total length and, when the conditions hold, the timestamp in place of the buffer-1 address word. Ownership bits, bus mastering, filtering and the MAC datapath lie outside the block.

Top module: `rx_desc_seq`

## Requirements
- R1: After reset the block is idle, with `frm_ready` high and no fetch, write or writeback activity. The first fetch after reset reads from `cfg_base`.
- R2: Size fields come from descriptor word 1: buffer 1 in bits 12:0 and buffer 2 in bits 28:16. Buffer 1 is written before buffer 2, each with length min(remaining, size). The address of buffer 1 is word 2 and the address of buffer 2 is word 3. Both addresses are used unaltered, even when they are not aligned.
- R3: When neither control flag is set, the next descriptor is at the current descriptor address plus 16.
- R4: When bit 15 of word 1 (end of table) is set, the next descriptor is at `cfg_base`.
- R5: When bit 14 of word 1 (linked mode) is set, word 3 is the next descriptor address, and no write goes to buffer 2 regardless of its size field.
- R6: When bits 15 and 14 are both set, the next descriptor is at `cfg_base`.
- R7: A zero buffer-1 size skips buffer 1. Data then goes to buffer 2 in ring mode, or the block moves on to the next descriptor in linked mode. A descriptor that received no data produces no writeback.
- R8: In ring mode, a descriptor with both sizes zero is passed over with no write and no writeback.
- R9: A frame that exceeds one descriptor's buffers continues on the following descriptors. The writeback of each such non-final descriptor has `wb_last`=0 and `wb_len`=0.
- R10: The descriptor on which the frame's remaining length reaches zero gives a writeback with `wb_last`=1 and `wb_len` equal to the frame length. The block then returns to idle.
- R11: On a final writeback, `wb_w2` equals the frame timestamp when both `cfg_ts_en` and `frm_ts_hit` are high. In every other writeback, `wb_w2` equals the fetched word 2.
- R12: A raised `fetch_req` or `wr_req` stays high, with its address and length unchanged, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Descriptor table base address |
| cfg_ts_en | input | 1 | Timestamp writeback enable |
| frm_ready | output | 1 | Idle, ready for a new frame |
| frm_start | input | 1 | Start a frame (taken while `frm_ready`) |
| frm_len | input | 16 | Frame length in bytes (nonzero) |
| frm_ts | input | 32 | Frame timestamp, low word |
| frm_ts_hit | input | 1 | Frame passed filtering and met the snapshot condition |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | 32 | Descriptor address |
| fetch_ack | input | 1 | Fetch complete; words valid |
| fetch_w1 | input | 32 | Descriptor word 1 (sizes, flags) |
| fetch_w2 | input | 32 | Descriptor word 2 (buffer 1 address) |
| fetch_w3 | input | 32 | Descriptor word 3 (buffer 2 or next-descriptor address) |
| wr_req | output | 1 | Buffer write request |
| wr_addr | output | 32 | Buffer start address |
| wr_len | output | 16 | Bytes for this buffer |
| wr_ack | input | 1 | Buffer write accepted |
| wb_valid | output | 1 | Descriptor writeback strobe (one cycle) |
| wb_addr | output | 32 | Address of descriptor being written back |
| wb_last | output | 1 | Frame ended on this descriptor |
| wb_len | output | 16 | Frame length on last descriptor, else 0 |
| wb_w2 | output | 32 | Value for word 2 (timestamp or address) |

## Verification
The assertions check the request-holding rules on every cycle, together with the bound on each write length against the remaining byte count. They also check the quiet idle state, the return to the base after an end-of-table descriptor, the absence of buffer-2 writes in linked mode, and the retained word 2 on non-final writebacks. The order in which descriptors are visited, the skipping of empty and zero-size buffers, frames that wrap over the table end, and the timestamp substitution depend on table contents spread over many cycles. Only the bench's scenarios, compared against an independently walked model of the table, can show those.

// File: rtl/rds_pkg.sv
package rds_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FETCH = 3'd1,
    S_BUF1  = 3'd2,
    S_BUF2  = 3'd3,
    S_WB    = 3'd4
  } rds_state_e;

  localparam int unsigned FLAG_END_BIT   = 15;
  localparam int unsigned FLAG_LINK_BIT  = 14;
  localparam int unsigned SIZE2_LSB      = 16;
endpackage

// File: rtl/rds_next_addr.sv
module rds_next_addr #(
  parameter int unsigned AW     = 32,
  parameter int unsigned STRIDE = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] link,
  input  logic          end_flag,
  input  logic          link_flag,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);

  always_comb begin
    if (end_flag)       nxt = base;   // end of table wins over linked mode
    else if (link_flag) nxt = link;
    else                nxt = cur + STEP;
  end
endmodule

// File: rtl/rds_chunk.sv
module rds_chunk #(
  parameter int unsigned LW = 16,
  parameter int unsigned SW = 13
) (
  input  logic [LW-1:0] remaining,
  input  logic [SW-1:0] size,
  output logic [LW-1:0] take,
  output logic          use_buf
);
  logic [LW-1:0] size_ext;

  always_comb begin
    size_ext = LW'(size);
    use_buf  = (size != '0) && (remaining != '0);
    take     = (remaining < size_ext) ? remaining : size_ext;
  end
endmodule

// File: rtl/rx_desc_seq.sv
module rx_desc_seq
  import rds_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned LW     = 16,
  parameter int unsigned SW     = 13,
  parameter int unsigned TW     = 32,
  parameter int unsigned STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic          cfg_ts_en,
  output logic          frm_ready,
  input  logic          frm_start,
  input  logic [LW-1:0] frm_len,
  input  logic [TW-1:0] frm_ts,
  input  logic          frm_ts_hit,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_ack,
  input  logic [31:0]   fetch_w1,
  input  logic [31:0]   fetch_w2,
  input  logic [31:0]   fetch_w3,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [LW-1:0] wr_len,
  input  logic          wr_ack,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic          wb_last,
  output logic [LW-1:0] wb_len,
  output logic [TW-1:0] wb_w2
);
  localparam int unsigned S2_MSB = SIZE2_LSB + SW - 1;

  rds_state_e    state_q, state_d;
  logic [AW-1:0] cur_q;
  logic          init_q;
  logic [LW-1:0] rem_q, rem_d;
  logic [LW-1:0] total_q;
  logic [TW-1:0] ts_q;
  logic          hit_q;
  logic [31:0]   w1_q, w2_q, w3_q;
  logic          wrote_q, wrote_d;

  logic          en_frame, en_desc, en_rem, en_adv, en_wrote;
  logic [AW-1:0] cur_eff, nxt_addr;
  logic [SW-1:0] size1, size2, size_sel;
  logic          flag_end, flag_link;
  logic [LW-1:0] ck_len;
  logic          ck_use;
  logic          in_buf;

  // ---------------- descriptor field decode ----------------
  always_comb begin
    size1     = w1_q[SW-1:0];
    size2     = w1_q[S2_MSB:SIZE2_LSB];
    flag_end  = w1_q[FLAG_END_BIT];
    flag_link = w1_q[FLAG_LINK_BIT];
    cur_eff   = init_q ? cur_q : cfg_base;
    in_buf    = (state_q == S_BUF1) || (state_q == S_BUF2);
    if (state_q == S_BUF2) size_sel = flag_link ? '0 : size2;
    else                   size_sel = size1;
  end

  rds_chunk #(.LW(LW), .SW(SW)) u_chunk (
    .remaining (rem_q),
    .size      (size_sel),
    .take      (ck_len),
    .use_buf   (ck_use)
  );

  rds_next_addr #(.AW(AW), .STRIDE(STRIDE)) u_next (
    .cur       (cur_eff),
    .base      (cfg_base),
    .link      (w3_q[AW-1:0]),
    .end_flag  (flag_end),
    .link_flag (flag_link),
    .nxt       (nxt_addr)
  );

  // ---------------- outputs ----------------
  always_comb begin
    frm_ready  = (state_q == S_IDLE);
    fetch_req  = (state_q == S_FETCH);
    fetch_addr = cur_eff;
    wr_req     = in_buf && ck_use;
    wr_addr    = (state_q == S_BUF2) ? w3_q[AW-1:0] : w2_q[AW-1:0];
    wr_len     = ck_len;
    wb_valid   = (state_q == S_WB) && wrote_q;
    wb_addr    = cur_eff;
    wb_last    = (rem_q == '0);
    wb_len     = wb_last ? total_q : '0;
    wb_w2      = (wb_last && cfg_ts_en && hit_q) ? ts_q : TW'(w2_q);
  end

  // ---------------- next state ----------------
  always_comb begin
    state_d  = state_q;
    rem_d    = rem_q;
    wrote_d  = wrote_q;
    en_frame = 1'b0;
    en_desc  = 1'b0;
    en_rem   = 1'b0;
    en_adv   = 1'b0;
    en_wrote = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (frm_start) begin
          en_frame = 1'b1;
          en_rem   = 1'b1;
          rem_d    = frm_len;
          state_d  = S_FETCH;
        end
      end
      S_FETCH: begin
        if (fetch_ack) begin
          en_desc  = 1'b1;
          en_wrote = 1'b1;
          wrote_d  = 1'b0;
          state_d  = S_BUF1;
        end
      end
      S_BUF1, S_BUF2: begin
        if (!ck_use || wr_ack) begin
          state_d = (state_q == S_BUF1) ? S_BUF2 : S_WB;
        end
        if (ck_use && wr_ack) begin
          en_rem   = 1'b1;
          rem_d    = rem_q - ck_len;
          en_wrote = 1'b1;
          wrote_d  = 1'b1;
        end
      end
      S_WB: begin
        en_adv  = 1'b1;
        state_d = (rem_q == '0) ? S_IDLE : S_FETCH;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      init_q  <= 1'b0;
      rem_q   <= '0;
      total_q <= '0;
      ts_q    <= '0;
      hit_q   <= 1'b0;
      w1_q    <= '0;
      w2_q    <= '0;
      w3_q    <= '0;
      wrote_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (en_rem)   rem_q   <= rem_d;
      if (en_wrote) wrote_q <= wrote_d;
      if (en_frame) begin
        total_q <= frm_len;
        ts_q    <= frm_ts;
        hit_q   <= frm_ts_hit;
      end
      if (en_desc) begin
        w1_q <= fetch_w1;
        w2_q <= fetch_w2;
        w3_q <= fetch_w3;
      end
      if (en_adv) begin
        cur_q  <= nxt_addr;
        init_q <= 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |-> (!fetch_req && !wr_req && !wb_valid));

  p_wr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_len != '0 && wr_len <= rem_q));

  p_end_to_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WB && rem_q != '0 && flag_end) |=> (fetch_addr == $past(cfg_base)));

  p_link_no_buf2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && state_q == S_BUF2) |-> !flag_link);

  p_w2_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_last) |-> (wb_w2 == TW'(w2_q)));

  p_fetch_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));

  p_wr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_len)));
endmodule

// File: tb/rx_desc_seq_tb.sv
`timescale 1ns/1ps
module rx_desc_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_base;
  logic        cfg_ts_en;
  logic        frm_ready, frm_start, frm_ts_hit;
  logic [15:0] frm_len;
  logic [31:0] frm_ts;
  logic        fetch_req, fetch_ack;
  logic [31:0] fetch_addr, fetch_w1, fetch_w2, fetch_w3;
  logic        wr_req, wr_ack;
  logic [31:0] wr_addr;
  logic [15:0] wr_len;
  logic        wb_valid, wb_last;
  logic [31:0] wb_addr, wb_w2;
  logic [15:0] wb_len;

  always #2.5 clk = ~clk;

  rx_desc_seq u_dut (
    .clk, .rst_n, .cfg_base, .cfg_ts_en, .frm_ready, .frm_start, .frm_len,
    .frm_ts, .frm_ts_hit, .fetch_req, .fetch_addr, .fetch_ack, .fetch_w1,
    .fetch_w2, .fetch_w3, .wr_req, .wr_addr, .wr_len, .wr_ack, .wb_valid,
    .wb_addr, .wb_last, .wb_len, .wb_w2
  );

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  logic [31:0] dmem [logic [31:0]];
  logic [31:0] mptr;
  logic [31:0] q_fetch [$];
  logic [31:0] q_waddr [$];
  logic [15:0] q_wlen  [$];
  logic [31:0] q_bwa   [$];
  logic        q_blast [$];
  logic [15:0] q_blen  [$];
  logic [31:0] q_bw2   [$];
  logic        wr_stall = 1'b0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return dmem.exists(a) ? dmem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mk_w1(input int s1, input int s2, input bit fin, input bit lnk);
    return {3'b0, 13'(s2), fin, lnk, 1'b0, 13'(s1)};
  endfunction

  task automatic setd(input logic [31:0] a, input logic [31:0] w1,
                      input logic [31:0] w2, input logic [31:0] w3);
    dmem[a + 4] = w1; dmem[a + 8] = w2; dmem[a + 12] = w3;
  endtask

  // Behavioural walk of the table: builds expected event streams.
  task automatic model_frame(input int len, input logic [31:0] ts, input bit hit);
    int rem = len;
    for (int g = 0; g < 64 && rem > 0; g++) begin
      logic [31:0] w1 = rd(mptr + 4), w2 = rd(mptr + 8), w3 = rd(mptr + 12);
      int s1 = int'(w1[12:0]);
      int s2 = int'(w1[28:16]);
      bit fin = w1[15], lnk = w1[14], wrote = 0;
      q_fetch.push_back(mptr);
      if (s1 > 0) begin
        int n = (rem < s1) ? rem : s1;
        q_waddr.push_back(w2); q_wlen.push_back(16'(n)); rem -= n; wrote = 1;
      end
      if (!lnk && s2 > 0 && rem > 0) begin
        int n = (rem < s2) ? rem : s2;
        q_waddr.push_back(w3); q_wlen.push_back(16'(n)); rem -= n; wrote = 1;
      end
      if (wrote) begin
        q_bwa.push_back(mptr);
        q_blast.push_back(rem == 0);
        q_blen.push_back(rem == 0 ? 16'(len) : 16'h0);
        q_bw2.push_back((rem == 0 && cfg_ts_en && hit) ? ts : w2);
      end
      mptr = fin ? cfg_base : (lnk ? w3 : mptr + 32'd16);
    end
  endtask

  // Responders and per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (fetch_ack) fetch_ack = 1'b0;
      else if (fetch_req) begin
        if (q_fetch.size() == 0) chk("unexpected fetch", {32'h0, fetch_addr}, 64'hFFFF);
        else chk("fetch_addr", {32'h0, fetch_addr}, {32'h0, q_fetch.pop_front()});
        fetch_w1 = rd(fetch_addr + 4);
        fetch_w2 = rd(fetch_addr + 8);
        fetch_w3 = rd(fetch_addr + 12);
        fetch_ack = 1'b1;
      end
      if (wr_ack) wr_ack = 1'b0;
      else if (wr_req) begin
        if (!wr_stall) wr_stall = 1'b1;   // hold request one cycle (R12)
        else begin
          wr_stall = 1'b0;
          if (q_waddr.size() == 0) chk("unexpected write", {32'h0, wr_addr}, 64'hFFFF);
          else begin
            chk("wr_addr", {32'h0, wr_addr}, {32'h0, q_waddr.pop_front()});
            chk("wr_len",  {48'h0, wr_len},  {48'h0, q_wlen.pop_front()});
          end
          wr_ack = 1'b1;
        end
      end
      if (wb_valid) begin
        if (q_bwa.size() == 0) chk("unexpected writeback", {32'h0, wb_addr}, 64'hFFFF);
        else begin
          chk("wb_addr", {32'h0, wb_addr}, {32'h0, q_bwa.pop_front()});
          chk("wb_last", {63'h0, wb_last}, {63'h0, q_blast.pop_front()});
          chk("wb_len",  {48'h0, wb_len},  {48'h0, q_blen.pop_front()});
          chk("wb_w2",   {32'h0, wb_w2},   {32'h0, q_bw2.pop_front()});
        end
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; frm_start = 1'b0; fetch_ack = 1'b0; wr_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mptr = cfg_base;
    @(negedge clk);
  endtask

  task automatic run_frame(input string t, input int len, input logic [31:0] ts, input bit hit);
    tag = t;
    model_frame(len, ts, hit);
    @(negedge clk);
    frm_start = 1'b1; frm_len = 16'(len); frm_ts = ts; frm_ts_hit = hit;
    @(negedge clk);
    frm_start = 1'b0;
    for (int i = 0; i < 2000 && !frm_ready; i++) @(negedge clk);
    chk("frame complete", {63'h0, frm_ready}, 64'h1);
    chk("events left", 64'(q_fetch.size() + q_waddr.size() + q_bwa.size()), 64'h0);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cfg_base = 32'h1000; cfg_ts_en = 1'b1;
    fetch_w1 = '0; fetch_w2 = '0; fetch_w3 = '0;
    frm_len = '0; frm_ts = '0; frm_ts_hit = 1'b0;
    do_reset();
    // R1: idle state after reset
    tag = "R1";
    chk("frm_ready", {63'h0, frm_ready}, 64'h1);
    chk("fetch_req", {63'h0, fetch_req}, 64'h0);
    chk("wr_req",    {63'h0, wr_req},    64'h0);
    chk("wb_valid",  {63'h0, wb_valid},  64'h0);

    // Table
    setd(32'h1000, mk_w1(64, 0, 0, 0),  32'h2003, 32'h0);     // ring, unaligned buf1
    setd(32'h1010, mk_w1(0, 40, 0, 0),  32'h2100, 32'h2200);  // buf1 empty -> buf2
    setd(32'h1020, mk_w1(0, 0, 0, 0),   32'h2300, 32'h2400);  // both empty, ring
    setd(32'h1030, mk_w1(0, 12, 0, 1),  32'h2500, 32'h1100);  // linked, buf1 empty
    setd(32'h1100, mk_w1(16, 80, 0, 1), 32'h2600, 32'h1200);  // linked, buf2 size ignored
    setd(32'h1200, mk_w1(32, 0, 1, 1),  32'h2700, 32'h1300);  // end + linked

    // R2 R3 R7 R9 R10 R11: spans two descriptors, timestamp written back
    run_frame("R2/R3/R7/R9/R10/R11", 100, 32'hCAFE_0001, 1'b1);
    // R8 R5 R7 R11: empty ring descriptor, skipped linked one, no snapshot
    run_frame("R8/R5/R7/R11", 8, 32'hCAFE_0002, 1'b0);
    // R6 R4 R9: wraps from end-of-table back to base, timestamps disabled
    cfg_ts_en = 1'b0;
    run_frame("R6/R4/R9/R12", 200, 32'hCAFE_0003, 1'b1);
    // R2 R4 R10: both buffers of one descriptor used, then end of table
    cfg_ts_en = 1'b1;
    setd(32'h1010, mk_w1(20, 40, 1, 0), 32'h2801, 32'h2902);
    run_frame("R2/R4/R10/R11", 50, 32'hCAFE_0004, 1'b1);
    // R1: after a fresh reset the walk restarts at the base
    do_reset();
    run_frame("R1/R10", 4, 32'hCAFE_0005, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule